// File: doc/BRIEF.md
# GPIO Pin Multiplexer and Pad Configuration Bank

This block holds the settings for a row of general-purpose pins and turns them into pad controls. Each pin owns two registers on a small word-addressed bus. The first is a control register that picks the pin's function, its pull bias, a drive-strength code and an output enable. The second is an I/O register with the value the pin drives and a read-only copy of the level on the pad.

A function code of zero leaves the pin under software control. Any other code hands the pad's output and output enable to one of seven alternate-function sources for that pin. The pad input passes through a two-stage synchronizer before software can read it. To switch a pin to output without a glitch, software loads the output value first and sets the enable afterwards. The pad already carries that value while the enable is still low.

Top module: `pin_mux_bank`

## Requirements
- R1: Pin p's control register is at word address 2p and its I/O register is at word address 2p+1. Reads return the addressed register combinationally, and a write takes effect at the rising clock edge on which bus_we is high.
- R2: Control register fields: bits [2:0] function code, bits [4:3] pull code, bits [7:5] drive code, bit 8 output enable. All other bits ignore writes and read as zero.
- R3: I/O register fields: bit 0 output value (read/write), bit 1 synchronized pad input (read-only, writes to it are ignored). All other bits read as zero.
- R4: While rst_n is low, every register is cleared. This gives function 0, output enable 0, pull code 0, drive code 0 and output value 0, so every pad output, pull and drive signal is 0.
- R5: Pull code 1 asserts pad_pd only and code 3 asserts pad_pu only. Codes 0 and 2 assert neither. pad_pu and pad_pd are never both high for the same pin.
- R6: pad_drive carries each pin's 3-bit drive code unchanged, with code c selecting (c+1)*2 mA. The code changes only when that pin's control register is written.
- R7: With function code 0, pad_out follows the output-value bit and pad_oe follows the output-enable bit, from the cycle after the write.
- R8: With function code k (1 to 7), pad_out[p] = alt_out[p*7+k-1] and pad_oe[p] = alt_oe[p*7+k-1], combinationally.
- R9: pad_out follows the output-value bit even while the output enable is 0, so the value can be loaded before the enable is set. A write to the I/O register leaves pad_oe unchanged.
- R10: A pad_in level sampled at one rising edge appears in the input bit after the next rising edge, and not before.
- R11: A write to one pin's register leaves every other pin's registers and pad signals unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W = clog2(2*NUM_PINS) | Word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pu | output | NUM_PINS | Pull-up enables |
| pad_pd | output | NUM_PINS | Pull-down enables |
| pad_drive | output | NUM_PINS*3 | Drive codes, pin p at [3p+2:3p] |
| alt_out | input | NUM_PINS*7 | Alternate-function output values, pin p function k at index p*7+k-1 |
| alt_oe | input | NUM_PINS*7 | Alternate-function output enables, same indexing |

## Verification
The bench builds the bank with NUM_PINS = 4 and DATA_W = 32. This gives a fully populated 3-bit address space, so every address reaches a real register, and four pins are enough to show that writes to one pin stay isolated from its neighbours. Because the function field keeps its full 3-bit width, all seven alternate-function slots of every pin can be selected. Random full-width write data also exercises the reserved pull code and the unused upper bits.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
    localparam int FUNC_W     = 3;
    localparam int PULL_W     = 2;
    localparam int DRIVE_W    = 3;
    localparam int CTL_W      = 1 + DRIVE_W + PULL_W + FUNC_W;
    localparam int NUM_ALT    = (1 << FUNC_W) - 1;
    localparam int IO_OUT_BIT = 0;
    localparam int IO_IN_BIT  = 1;

    typedef enum logic [PULL_W-1:0] {
        PULL_NONE = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_RSVD = 2'd2,
        PULL_UP   = 2'd3
    } pull_e;

    // Packed MSB first: oe at bit 8, drive [7:5], pull [4:3], func [2:0]
    typedef struct packed {
        logic               oe;
        logic [DRIVE_W-1:0] drive;
        pull_e              pull;
        logic [FUNC_W-1:0]  func;
    } pin_ctl_t;

    typedef struct packed {
        pin_ctl_t ctl;
        logic     out;
    } pin_state_t;
endpackage

// File: rtl/pin_input_sync.sv
module pin_input_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = raw_i;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.stage2;
endmodule

// File: rtl/pin_cfg_slot.sv
module pin_cfg_slot
    import pinmux_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we_i,
    input  logic             io_we_i,
    input  logic [CTL_W-1:0] wdata_i,
    output pin_ctl_t         ctl_o,
    output logic             out_o
);
    pin_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (ctl_we_i) state_d.ctl = pin_ctl_t'(wdata_i);
        if (io_we_i)  state_d.out = wdata_i[IO_OUT_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ctl_o = state_q.ctl;
    assign out_o = state_q.out;
endmodule

// File: rtl/pin_pad_route.sv
module pin_pad_route
    import pinmux_pkg::*;
(
    input  pin_ctl_t           ctl_i,
    input  logic               gpio_out_i,
    input  logic [NUM_ALT-1:0] alt_out_i,
    input  logic [NUM_ALT-1:0] alt_oe_i,
    output logic               pad_out_o,
    output logic               pad_oe_o,
    output logic               pad_pu_o,
    output logic               pad_pd_o,
    output logic [DRIVE_W-1:0] pad_drive_o
);
    always_comb begin
        pad_out_o = gpio_out_i;
        pad_oe_o  = ctl_i.oe;
        for (int k = 1; k <= NUM_ALT; k++) begin
            if (ctl_i.func == FUNC_W'(k)) begin
                pad_out_o = alt_out_i[k-1];
                pad_oe_o  = alt_oe_i[k-1];
            end
        end
    end

    always_comb begin
        pad_pu_o    = (ctl_i.pull == PULL_UP);
        pad_pd_o    = (ctl_i.pull == PULL_DOWN);
        pad_drive_o = ctl_i.drive;
    end
endmodule

// File: rtl/pin_mux_bank.sv
module pin_mux_bank
    import pinmux_pkg::*;
#(
    parameter  int NUM_PINS = 8,
    parameter  int DATA_W   = 32,
    localparam int ADDR_W   = $clog2(2 * NUM_PINS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_we,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic [NUM_PINS-1:0]           pad_in,
    output logic [NUM_PINS-1:0]           pad_out,
    output logic [NUM_PINS-1:0]           pad_oe,
    output logic [NUM_PINS-1:0]           pad_pu,
    output logic [NUM_PINS-1:0]           pad_pd,
    output logic [NUM_PINS*DRIVE_W-1:0]   pad_drive,
    input  logic [NUM_PINS*NUM_ALT-1:0]   alt_out,
    input  logic [NUM_PINS*NUM_ALT-1:0]   alt_oe
);
    localparam int PIN_W = ADDR_W - 1;

    logic [PIN_W-1:0]    pin_idx;
    logic                sel_io;
    pin_ctl_t            ctl_arr [NUM_PINS];
    logic [NUM_PINS-1:0] out_arr;
    logic [NUM_PINS-1:0] in_sync;
    logic                unused_wdata;

    assign pin_idx      = bus_addr[ADDR_W-1:1];
    assign sel_io       = bus_addr[0];
    assign unused_wdata = ^bus_wdata[DATA_W-1:CTL_W];

    pin_input_sync #(.WIDTH(NUM_PINS)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pad_in),
        .sync_o (in_sync)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic ctl_we, io_we;

        assign ctl_we = bus_we && (bus_addr == ADDR_W'(2 * p));
        assign io_we  = bus_we && (bus_addr == ADDR_W'(2 * p + 1));

        pin_cfg_slot i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_we_i (ctl_we),
            .io_we_i  (io_we),
            .wdata_i  (bus_wdata[CTL_W-1:0]),
            .ctl_o    (ctl_arr[p]),
            .out_o    (out_arr[p])
        );

        pin_pad_route i_route (
            .ctl_i       (ctl_arr[p]),
            .gpio_out_i  (out_arr[p]),
            .alt_out_i   (alt_out[p*NUM_ALT +: NUM_ALT]),
            .alt_oe_i    (alt_oe[p*NUM_ALT +: NUM_ALT]),
            .pad_out_o   (pad_out[p]),
            .pad_oe_o    (pad_oe[p]),
            .pad_pu_o    (pad_pu[p]),
            .pad_pd_o    (pad_pd[p]),
            .pad_drive_o (pad_drive[p*DRIVE_W +: DRIVE_W])
        );
    end

    // Read path: addresses beyond the last pin return zero
    always_comb begin
        bus_rdata = '0;
        if (32'(pin_idx) < NUM_PINS) begin
            if (sel_io) begin
                bus_rdata[IO_OUT_BIT] = out_arr[pin_idx];
                bus_rdata[IO_IN_BIT]  = in_sync[pin_idx];
            end else begin
                bus_rdata[CTL_W-1:0] = ctl_arr[pin_idx];
            end
        end
    end
endmodule

// File: rtl/pin_mux_bank_chk.sv
module pin_mux_bank_chk
    import pinmux_pkg::*;
#(
    parameter  int NUM_PINS = 8,
    parameter  int DATA_W   = 32,
    localparam int ADDR_W   = $clog2(2 * NUM_PINS)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_we,
    input logic [DATA_W-1:0]           bus_wdata,
    input logic [NUM_PINS-1:0]         pad_in,
    input logic [NUM_PINS-1:0]         in_sync,
    input logic [NUM_PINS-1:0]         pad_oe,
    input logic [NUM_PINS-1:0]         pad_pu,
    input logic [NUM_PINS-1:0]         pad_pd,
    input logic [NUM_PINS*DRIVE_W-1:0] pad_drive
);
    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    // R5
    pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);

    // R10
    input_two_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2) |-> (in_sync == $past(pad_in, 2)));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        // R6
        drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_we && bus_addr == ADDR_W'(2 * p))
            |=> $stable(pad_drive[p*DRIVE_W +: DRIVE_W]));

        // R7
        gpio_oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ADDR_W'(2 * p) && bus_wdata[FUNC_W-1:0] == '0)
            |=> (pad_oe[p] == $past(bus_wdata[CTL_W-1])));
    end
endmodule

bind pin_mux_bank pin_mux_bank_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pad_in    (pad_in),
    .in_sync   (in_sync),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .pad_drive (pad_drive)
);

// File: tb/test_pin_mux_bank.sv
`timescale 1ns/1ps
module test_pin_mux_bank;
    localparam int NP = 4;
    localparam int NA = 7;
    localparam int AW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   pad_out, pad_oe, pad_pu, pad_pd;
    logic [NP*3-1:0] pad_drive;
    logic [NP*NA-1:0] alt_out = '0;
    logic [NP*NA-1:0] alt_oe = '0;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    logic [8:0]    ctl_m [NP];
    logic [NP-1:0] out_m = '0;
    logic [NP-1:0] in_m  = '0;

    pin_mux_bank #(.NUM_PINS(NP), .DATA_W(32)) i_pin_mux_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_drive(pad_drive), .alt_out(alt_out), .alt_oe(alt_oe)
    );

    always #4 clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        finish_run();
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (a[0]) out_m[a[2:1]] = d[0];
        else      ctl_m[a[2:1]] = d[8:0];
    endtask

    function automatic logic exp_out(int p);
        logic [2:0] f = ctl_m[p][2:0];
        return (f == 0) ? out_m[p] : alt_out[p*NA + int'(f) - 1];
    endfunction

    function automatic logic exp_oe(int p);
        logic [2:0] f = ctl_m[p][2:0];
        return (f == 0) ? ctl_m[p][8] : alt_oe[p*NA + int'(f) - 1];
    endfunction

    task automatic check_all();
        logic [31:0] d;
        for (int p = 0; p < NP; p++) begin
            rd(AW'(2*p), d);
            chk("R2 R11 control readback", d, {23'b0, ctl_m[p]});
            rd(AW'(2*p+1), d);
            chk("R3 R11 io readback", d, {30'b0, in_m[p], out_m[p]});
            if (ctl_m[p][2:0] == 3'd0) begin
                chk("R7 gpio pad_out", 32'(pad_out[p]), 32'(exp_out(p)));
                chk("R7 gpio pad_oe", 32'(pad_oe[p]), 32'(exp_oe(p)));
            end else begin
                chk("R8 alt pad_out", 32'(pad_out[p]), 32'(exp_out(p)));
                chk("R8 alt pad_oe", 32'(pad_oe[p]), 32'(exp_oe(p)));
            end
            chk("R5 pull-up", 32'(pad_pu[p]), 32'(ctl_m[p][4:3] == 2'd3));
            chk("R5 pull-down", 32'(pad_pd[p]), 32'(ctl_m[p][4:3] == 2'd1));
            chk("R6 drive code", 32'(pad_drive[p*3 +: 3]), 32'(ctl_m[p][7:5]));
        end
    endtask

    task automatic drive_in(logic [NP-1:0] v);
        logic [31:0] d;
        @(negedge clk);
        pad_in = v;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            rd(AW'(2*p+1), d);
            chk("R10 input not yet visible", 32'(d[1]), 32'(in_m[p]));
        end
        @(negedge clk);
        in_m = v;
        for (int p = 0; p < NP; p++) begin
            rd(AW'(2*p+1), d);
            chk("R10 input after two edges", 32'(d[1]), 32'(v[p]));
        end
    endtask

    initial begin
        logic [31:0] d;
        int unsigned seed_init;
        seed_init = $urandom(32'h5EED_0042);
        for (int p = 0; p < NP; p++) ctl_m[p] = '0;

        repeat (3) @(negedge clk);
        pad_in = 4'b1111;
        @(negedge clk);
        chk("R4 pad_oe in reset", 32'(pad_oe), 32'h0);
        chk("R4 pad_drive in reset", 32'(pad_drive), 32'h0);
        pad_in = '0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all();

        // R1: pin 3 control is at 6, its io at 7
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd7, d);
        chk("R1 io address distinct from control", d, 32'h0);
        rd(3'd6, d);
        chk("R1 R2 control at 2p", d, 32'h0000_01FF);
        wr(3'd6, 32'h0);

        // R5: every pull code on pin 1, including reserved code 2
        for (int c = 0; c < 4; c++) begin
            wr(3'd2, 32'(c) << 3);
            chk("R5 pull-up code", 32'(pad_pu[1]), 32'(c == 3));
            chk("R5 pull-down code", 32'(pad_pd[1]), 32'(c == 1));
        end

        // R6: every drive code on pin 2
        for (int c = 0; c < 8; c++) begin
            wr(3'd4, 32'(c) << 5);
            chk("R6 drive passthrough", 32'(pad_drive[6 +: 3]), 32'(c));
        end

        // R9: preload output value, then enable
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h1);
        chk("R9 value preloaded while disabled", 32'(pad_out[0]), 32'h1);
        chk("R9 io write keeps oe low", 32'(pad_oe[0]), 32'h0);
        wr(3'd0, 32'h100);
        chk("R9 enable after preload oe", 32'(pad_oe[0]), 32'h1);
        chk("R9 enable after preload out", 32'(pad_out[0]), 32'h1);
        wr(3'd1, 32'h0);
        chk("R9 io write keeps oe high", 32'(pad_oe[0]), 32'h1);

        // R3: writing the input bit has no effect
        drive_in(4'b0000);
        wr(3'd3, 32'hFFFF_FFFE);
        rd(3'd3, d);
        chk("R3 input bit write ignored", d, 32'h0);

        // R8: each alternate slot of pin 2, one-hot source pattern
        for (int k = 1; k <= NA; k++) begin
            wr(3'd4, 32'(k));
            @(negedge clk);
            alt_out = '0; alt_oe = '1;
            alt_out[2*NA + k - 1] = 1'b1;
            alt_oe[2*NA + k - 1]  = 1'b0;
            #0.1;
            chk("R8 slot out select", 32'(pad_out[2]), 32'h1);
            chk("R8 slot oe select", 32'(pad_oe[2]), 32'h0);
        end
        check_all();

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int unsigned op = $urandom_range(0, 3);
            int unsigned pin = $urandom_range(0, NP - 1);
            case (op)
                0: wr(AW'(2*pin), $urandom());
                1: wr(AW'(2*pin+1), $urandom());
                2: drive_in(NP'($urandom()));
                default: begin
                    @(negedge clk);
                    alt_out = NP*NA'({$urandom(), $urandom()});
                    alt_oe  = NP*NA'({$urandom(), $urandom()});
                end
            endcase
            check_all();
        end

        finish_run();
    end
endmodule